// File: doc/BRIEF.md
# Fractional MAC with convergent rounding

This block is the arithmetic core of a 24-bit fixed-point signal processor. It holds four 24-bit operand registers and two 56-bit accumulators. Each operation multiplies two operand registers as signed fractions and adds the product to, or subtracts it from, one accumulator. It can then round the result to the word boundary, using round-half-to-even. The whole operation finishes in a single clock with no pipeline stages. The new accumulator value and four condition flags are registered at the same edge.

Each accumulator is organised as an 8-bit extension over two 24-bit words. Software-visible traffic is modelled by two kinds of port. A load port writes an operand register or one accumulator segment. A combinational segment read port returns any one segment on a 24-bit bus. The extension segment reads back sign-extended. The two operand pairs are also presented as 48-bit concatenated values.

Top module: `frac_mac_unit`

## Requirements
- R1: While `rst_n` is low, all operand registers, both accumulators and all four flags are cleared to zero.
- R2: A write with `in_we` high stores `in_data` at the next edge into the operand register chosen by `in_sel`, coded 0 = X0, 1 = X1, 2 = Y0, 3 = Y1. `x_pair` shows {X1,X0} and `y_pair` shows {Y1,Y0}.
- R3: A write with `acc_we` high loads one segment of the accumulator chosen by `acc_wsel` (0 = A, 1 = B) at the next edge. Segment code 0 loads bits 55:48 from `acc_wdata[7:0]` and ignores `acc_wdata[23:8]`. Code 1 loads bits 47:24 and code 2 loads bits 23:0. Code 3 changes nothing.
- R4: `rd_data` shows the segment of the accumulator selected by `rd_acc`/`rd_seg` in the same cycle, using the segment codes of R3. For code 0, bits 7:0 hold bits 55:48 and bits 23:8 repeat bit 55. Code 3 reads zero.
- R5: When `op_valid` is high, the accumulator chosen by `op_dst` (0 = A, 1 = B) takes a new value at the next edge: old value + 2·(src_a × src_b), modulo 2^56. The operands are signed 24-bit values picked by `op_src_a`/`op_src_b` with the codes of R2, and the product is sign-extended to 56 bits.
- R6: With `op_sub` high, the doubled product is subtracted instead of added, modulo 2^56.
- R7: With `op_rnd` high, the sum is rounded at bit 24 and bits 23:0 are cleared. A low word above 0x800000 rounds up and a low word below it rounds down. A low word of exactly 0x800000 rounds up only when bit 24 of the sum is 1, so the kept part ends even.
- R8: With every operation, the flags are registered from the final, post-round result. `flag_n` is bit 55, `flag_z` is set when all 56 bits are zero, and `flag_e` is set when bits 55:47 are not all equal.
- R9: `flag_v` is set after an operation whose 56-bit signed add or subtract overflowed, and cleared after one that did not.
- R10: If an operation and a segment load name the same accumulator in one cycle, the operation's result is stored and the load is dropped. An operation leaves the other accumulator unchanged unless that accumulator is loaded in the same cycle.
- R11: In cycles without `op_valid`, all four flags keep their values. In cycles with neither `op_valid` nor `acc_we`, both accumulators keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_we | input | 1 | Operand register write strobe |
| in_sel | input | 2 | Operand register select |
| in_data | input | 24 | Operand write data |
| acc_we | input | 1 | Accumulator segment write strobe |
| acc_wsel | input | 1 | Accumulator select for segment write |
| acc_wseg | input | 2 | Segment select for write |
| acc_wdata | input | 24 | Segment write data |
| op_valid | input | 1 | Start a multiply-accumulate this cycle |
| op_src_a | input | 2 | First multiplier source |
| op_src_b | input | 2 | Second multiplier source |
| op_dst | input | 1 | Destination accumulator |
| op_sub | input | 1 | Subtract product instead of add |
| op_rnd | input | 1 | Apply convergent rounding |
| rd_acc | input | 1 | Accumulator select for segment read |
| rd_seg | input | 2 | Segment select for read |
| rd_data | output | 24 | Segment read data |
| x_pair | output | 48 | Concatenated X1:X0 |
| y_pair | output | 48 | Concatenated Y1:Y0 |
| acc_a | output | 56 | Accumulator A |
| acc_b | output | 56 | Accumulator B |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_e | output | 1 | Extension-in-use flag |

## Verification
Operand loads, segment loads, accumulator results and flags are all due at the first rising edge after the cycle in which they are presented. The segment read port is combinational and is valid in the cycle its select is driven. The bench drives every input on a falling edge and advances its model across the following rising edge. It compares every output on the next falling edge, so each comparison lands exactly one edge after its stimulus and never races the clock. The directed cases include ties with even and odd bit 24, the most negative operand squared, and both add and subtract overflow. A randomised stream follows them.

// File: rtl/fmac_pkg.sv
package fmac_pkg;

   typedef enum logic [1:0] {
      SRC_X0 = 2'd0,
      SRC_X1 = 2'd1,
      SRC_Y0 = 2'd2,
      SRC_Y1 = 2'd3
   } src_e;

   typedef enum logic [1:0] {
      SEG_EXT  = 2'd0,
      SEG_HIGH = 2'd1,
      SEG_LOW  = 2'd2,
      SEG_NONE = 2'd3
   } seg_e;

   typedef struct packed {
      logic n;
      logic z;
      logic v;
      logic e;
   } flags_t;

endpackage

// File: rtl/fmac_mult.sv
// Signed fractional multiplier: 2*a*b, sign-extended to the accumulator width.
module fmac_mult #(
   parameter int DATA_W = 24,
   parameter int ACC_W  = 56
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [ACC_W-1:0]  prod
);
   localparam int PW = 2 * DATA_W;

   logic signed [PW-1:0] raw;
   logic [ACC_W-1:0]     wide;

   always_comb begin
      raw  = $signed(a) * $signed(b);
      // widen before the shift so that (-1)*(-1) = +1.0 is representable
      wide = {{(ACC_W-PW){raw[PW-1]}}, raw};
      prod = wide << 1;
   end
endmodule

// File: rtl/fmac_accum.sv
// Add/subtract into the accumulator, detect overflow, optional rounding.
module fmac_accum #(
   parameter int DATA_W   = 24,
   parameter int ACC_W    = 56,
   parameter int RND_MODE = 0   // 0: convergent, 1: round half up
) (
   input  logic [ACC_W-1:0] acc,
   input  logic [ACC_W-1:0] prod,
   input  logic             sub,
   input  logic             rnd,
   output logic [ACC_W-1:0] res,
   output logic             ovf
);
   localparam logic [ACC_W-1:0] HALF = ACC_W'(1) << (DATA_W - 1);

   logic [ACC_W-1:0] sum;
   logic [ACC_W-1:0] bumped;
   logic             tie;
   logic             tie_kill;

   assign tie = (sum[DATA_W-1:0] == HALF[DATA_W-1:0]);

   generate
      if (RND_MODE == 0) begin : g_convergent
         assign tie_kill = tie;
      end else begin : g_half_up
         assign tie_kill = 1'b0;
      end
   endgenerate

   always_comb begin
      sum = sub ? (acc - prod) : (acc + prod);
      if (sub)
         ovf = (acc[ACC_W-1] != prod[ACC_W-1]) && (sum[ACC_W-1] != acc[ACC_W-1]);
      else
         ovf = (acc[ACC_W-1] == prod[ACC_W-1]) && (sum[ACC_W-1] != acc[ACC_W-1]);
      bumped = sum + HALF;
      if (tie_kill)
         bumped[DATA_W] = 1'b0;
      bumped[DATA_W-1:0] = '0;
      res = rnd ? bumped : sum;
   end
endmodule

// File: rtl/fmac_flags.sv
// Condition flags from the final accumulator result.
module fmac_flags #(
   parameter int DATA_W = 24,
   parameter int ACC_W  = 56
) (
   input  logic [ACC_W-1:0]     res,
   input  logic                 ovf,
   output fmac_pkg::flags_t     flags
);
   localparam int TOP_LO = 2 * DATA_W - 1;

   logic [ACC_W-1:TOP_LO] top;

   always_comb begin
      top     = res[ACC_W-1:TOP_LO];
      flags.n = res[ACC_W-1];
      flags.z = (res == '0);
      flags.v = ovf;
      flags.e = !((&top) || (~|top));
   end
endmodule

// File: rtl/frac_mac_unit.sv
module frac_mac_unit #(
   parameter int DATA_W   = 24,
   parameter int EXT_W    = 8,
   parameter int RND_MODE = 0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  in_we,
   input  logic [1:0]            in_sel,
   input  logic [DATA_W-1:0]     in_data,
   input  logic                  acc_we,
   input  logic                  acc_wsel,
   input  logic [1:0]            acc_wseg,
   input  logic [DATA_W-1:0]     acc_wdata,
   input  logic                  op_valid,
   input  logic [1:0]            op_src_a,
   input  logic [1:0]            op_src_b,
   input  logic                  op_dst,
   input  logic                  op_sub,
   input  logic                  op_rnd,
   input  logic                  rd_acc,
   input  logic [1:0]            rd_seg,
   output logic [DATA_W-1:0]     rd_data,
   output logic [2*DATA_W-1:0]   x_pair,
   output logic [2*DATA_W-1:0]   y_pair,
   output logic [EXT_W+2*DATA_W-1:0] acc_a,
   output logic [EXT_W+2*DATA_W-1:0] acc_b,
   output logic                  flag_n,
   output logic                  flag_z,
   output logic                  flag_v,
   output logic                  flag_e
);
   import fmac_pkg::*;

   localparam int ACC_W = EXT_W + 2 * DATA_W;
   localparam int N_IN  = 4;
   localparam int N_ACC = 2;
   localparam int HI_LO = DATA_W;
   localparam int EX_LO = 2 * DATA_W;

   generate
      if (EXT_W < 1 || EXT_W >= DATA_W) begin : g_bad_ext
         $error("frac_mac_unit: EXT_W must lie in 1..DATA_W-1");
      end
      if (DATA_W < 4) begin : g_bad_data
         $error("frac_mac_unit: DATA_W must be at least 4");
      end
      if (RND_MODE != 0 && RND_MODE != 1) begin : g_bad_rnd
         $error("frac_mac_unit: RND_MODE must be 0 or 1");
      end
   endgenerate

   logic [DATA_W-1:0] in_q  [N_IN];
   logic [ACC_W-1:0]  acc_q [N_ACC];
   flags_t            flags_q;

   logic [ACC_W-1:0]  prod;
   logic [ACC_W-1:0]  res;
   logic              ovf;
   flags_t            flags_d;

   fmac_mult #(.DATA_W(DATA_W), .ACC_W(ACC_W)) i_mult (
      .a    (in_q[op_src_a]),
      .b    (in_q[op_src_b]),
      .prod (prod)
   );

   fmac_accum #(.DATA_W(DATA_W), .ACC_W(ACC_W), .RND_MODE(RND_MODE)) i_accum (
      .acc  (acc_q[op_dst]),
      .prod (prod),
      .sub  (op_sub),
      .rnd  (op_rnd),
      .res  (res),
      .ovf  (ovf)
   );

   fmac_flags #(.DATA_W(DATA_W), .ACC_W(ACC_W)) i_flags (
      .res   (res),
      .ovf   (ovf),
      .flags (flags_d)
   );

   // operand registers
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < N_IN; i++)
            in_q[i] <= '0;
      end else if (in_we) begin
         in_q[in_sel] <= in_data;
      end
   end

   // accumulators: an operation wins over a segment load to the same one
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < N_ACC; i++)
            acc_q[i] <= '0;
      end else begin
         for (int i = 0; i < N_ACC; i++) begin
            if (op_valid && (int'(op_dst) == i)) begin
               acc_q[i] <= res;
            end else if (acc_we && (int'(acc_wsel) == i)) begin
               case (seg_e'(acc_wseg))
                  SEG_EXT:  acc_q[i][ACC_W-1:EX_LO]  <= acc_wdata[EXT_W-1:0];
                  SEG_HIGH: acc_q[i][EX_LO-1:HI_LO]  <= acc_wdata;
                  SEG_LOW:  acc_q[i][HI_LO-1:0]      <= acc_wdata;
                  default:  acc_q[i]                 <= acc_q[i];
               endcase
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         flags_q <= '0;
      else if (op_valid)
         flags_q <= flags_d;
   end

   // segment read bus
   logic [ACC_W-1:0] rd_src;

   always_comb begin
      rd_src = acc_q[rd_acc];
      case (seg_e'(rd_seg))
         SEG_EXT:  rd_data = {{(DATA_W-EXT_W){rd_src[ACC_W-1]}}, rd_src[ACC_W-1:EX_LO]};
         SEG_HIGH: rd_data = rd_src[EX_LO-1:HI_LO];
         SEG_LOW:  rd_data = rd_src[HI_LO-1:0];
         default:  rd_data = '0;
      endcase
   end

   assign x_pair = {in_q[SRC_X1], in_q[SRC_X0]};
   assign y_pair = {in_q[SRC_Y1], in_q[SRC_Y0]};
   assign acc_a  = acc_q[0];
   assign acc_b  = acc_q[1];
   assign flag_n = flags_q.n;
   assign flag_z = flags_q.z;
   assign flag_v = flags_q.v;
   assign flag_e = flags_q.e;

endmodule

// File: rtl/fmac_chk.sv
module fmac_chk #(
   parameter int DATA_W = 24,
   parameter int EXT_W  = 8
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       op_valid,
   input logic                       op_dst,
   input logic                       op_rnd,
   input logic                       acc_we,
   input logic [1:0]                 rd_seg,
   input logic [DATA_W-1:0]          rd_data,
   input logic [EXT_W+2*DATA_W-1:0]  acc_a,
   input logic [EXT_W+2*DATA_W-1:0]  acc_b,
   input logic                       flag_n,
   input logic                       flag_z,
   input logic                       flag_v,
   input logic                       flag_e
);
   localparam int ACC_W = EXT_W + 2 * DATA_W;

   AST_EXT_SIGN_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_seg == 2'd0) |-> (rd_data[DATA_W-1:EXT_W] == {(DATA_W-EXT_W){rd_data[EXT_W-1]}})); // R4

   AST_IDLE_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!op_valid && !acc_we) |=> ($stable(acc_a) && $stable(acc_b))); // R11

   AST_IDLE_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> $stable({flag_n, flag_z, flag_v, flag_e})); // R11

   AST_ROUND_CLEARS_A: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_rnd && !op_dst) |=> (acc_a[DATA_W-1:0] == '0)); // R7

   AST_ROUND_CLEARS_B: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_rnd && op_dst) |=> (acc_b[DATA_W-1:0] == '0)); // R7

   AST_ZERO_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid |=> (flag_z == (($past(op_dst) ? acc_b : acc_a) == '0))); // R8

   AST_SIGN_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid |=> (flag_n == ($past(op_dst) ? acc_b[ACC_W-1] : acc_a[ACC_W-1]))); // R8

   AST_OTHER_B_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && !op_dst && !acc_we) |=> $stable(acc_b)); // R10

   AST_OTHER_A_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_dst && !acc_we) |=> $stable(acc_a)); // R10

endmodule

bind frac_mac_unit fmac_chk #(.DATA_W(DATA_W), .EXT_W(EXT_W)) i_fmac_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .op_valid (op_valid),
   .op_dst   (op_dst),
   .op_rnd   (op_rnd),
   .acc_we   (acc_we),
   .rd_seg   (rd_seg),
   .rd_data  (rd_data),
   .acc_a    (acc_a),
   .acc_b    (acc_b),
   .flag_n   (flag_n),
   .flag_z   (flag_z),
   .flag_v   (flag_v),
   .flag_e   (flag_e)
);

// File: tb/test_frac_mac_unit.sv
`timescale 1ns/1ps
module test_frac_mac_unit;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        in_we;
   logic [1:0]  in_sel;
   logic [23:0] in_data;
   logic        acc_we;
   logic        acc_wsel;
   logic [1:0]  acc_wseg;
   logic [23:0] acc_wdata;
   logic        op_valid;
   logic [1:0]  op_src_a, op_src_b;
   logic        op_dst, op_sub, op_rnd;
   logic        rd_acc;
   logic [1:0]  rd_seg;
   logic [23:0] rd_data;
   logic [47:0] x_pair, y_pair;
   logic [55:0] acc_a, acc_b;
   logic        flag_n, flag_z, flag_v, flag_e;

   always #5 clk = ~clk;

   frac_mac_unit i_frac_mac_unit (
      .clk(clk), .rst_n(rst_n),
      .in_we(in_we), .in_sel(in_sel), .in_data(in_data),
      .acc_we(acc_we), .acc_wsel(acc_wsel), .acc_wseg(acc_wseg), .acc_wdata(acc_wdata),
      .op_valid(op_valid), .op_src_a(op_src_a), .op_src_b(op_src_b),
      .op_dst(op_dst), .op_sub(op_sub), .op_rnd(op_rnd),
      .rd_acc(rd_acc), .rd_seg(rd_seg), .rd_data(rd_data),
      .x_pair(x_pair), .y_pair(y_pair), .acc_a(acc_a), .acc_b(acc_b),
      .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_e(flag_e)
   );

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   // reference state
   logic [23:0] m_in [4];
   logic [55:0] m_acc [2];
   bit m_n, m_z, m_v, m_e;

   task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic void ref_mac(input logic [55:0] acc, input logic [23:0] a,
                                   input logic [23:0] b, input bit sub, input bit rnd,
                                   output logic [55:0] r, output bit v);
      longint s_acc, s_prod, s_sum, trunc;
      int low;
      s_acc  = longint'($signed(acc));
      s_prod = longint'($signed(a)) * longint'($signed(b)) * 2;
      s_sum  = sub ? (s_acc - s_prod) : (s_acc + s_prod);
      v = (s_sum > ((64'sd1 <<< 55) - 1)) || (s_sum < -(64'sd1 <<< 55));
      r = s_sum[55:0];
      if (rnd) begin
         trunc = longint'($signed(r)) >>> 24;
         low   = int'(r[23:0]);
         if (low > 'h800000 || (low == 'h800000 && trunc[0]))
            trunc = trunc + 1;
         r = 56'(trunc <<< 24);
      end
   endfunction

   function automatic logic [23:0] ref_read(input logic [55:0] acc, input logic [1:0] seg);
      case (seg)
         2'd0: return {{16{acc[55]}}, acc[55:48]};
         2'd1: return acc[47:24];
         2'd2: return acc[23:0];
         default: return 24'd0;
      endcase
   endfunction

   task automatic idle();
      in_we = 0; in_sel = 0; in_data = 0;
      acc_we = 0; acc_wsel = 0; acc_wseg = 0; acc_wdata = 0;
      op_valid = 0; op_src_a = 0; op_src_b = 0; op_dst = 0; op_sub = 0; op_rnd = 0;
   endtask

   // advance one clock with the inputs currently driven, then compare
   task automatic cyc(string tag);
      logic [23:0] n_in [4];
      logic [55:0] n_acc [2];
      logic [55:0] r;
      bit v;
      n_in = m_in;
      n_acc = m_acc;
      if (in_we) n_in[in_sel] = in_data;
      if (acc_we && !(op_valid && op_dst == acc_wsel)) begin
         case (acc_wseg)
            2'd0: n_acc[acc_wsel][55:48] = acc_wdata[7:0];
            2'd1: n_acc[acc_wsel][47:24] = acc_wdata;
            2'd2: n_acc[acc_wsel][23:0]  = acc_wdata;
            default: ;
         endcase
      end
      if (op_valid) begin
         ref_mac(m_acc[op_dst], m_in[op_src_a], m_in[op_src_b], op_sub, op_rnd, r, v);
         n_acc[op_dst] = r;
         m_n = r[55];
         m_z = (r == 0);
         m_v = v;
         m_e = !((r[55:47] == 9'h1FF) || (r[55:47] == 9'h000));
      end
      @(posedge clk);
      m_in = n_in;
      m_acc = n_acc;
      @(negedge clk);
      check(tag, "acc_a", 64'(acc_a), 64'(m_acc[0]));
      check(tag, "acc_b", 64'(acc_b), 64'(m_acc[1]));
      check("R2", "x_pair", 64'(x_pair), 64'({m_in[1], m_in[0]}));
      check("R2", "y_pair", 64'(y_pair), 64'({m_in[3], m_in[2]}));
      check("R8", "flags nze", 64'({flag_n, flag_z, flag_e}), 64'({m_n, m_z, m_e}));
      check("R9", "flag_v", 64'(flag_v), 64'(m_v));
      check("R4", "rd_data", 64'(rd_data), 64'(ref_read(m_acc[rd_acc], rd_seg)));
      idle();
   endtask

   task automatic load_in(input logic [1:0] sel, input logic [23:0] d);
      in_we = 1; in_sel = sel; in_data = d;
      cyc("R2");
   endtask

   task automatic load_seg(input bit which, input logic [1:0] seg, input logic [23:0] d, input string tag);
      acc_we = 1; acc_wsel = which; acc_wseg = seg; acc_wdata = d;
      cyc(tag);
   endtask

   task automatic set_acc(input bit which, input logic [7:0] e, input logic [23:0] h, input logic [23:0] l);
      load_seg(which, 2'd0, {16'h0, e}, "R3");
      load_seg(which, 2'd1, h, "R3");
      load_seg(which, 2'd2, l, "R3");
   endtask

   task automatic mac(input logic [1:0] sa, input logic [1:0] sb, input bit dst,
                      input bit sub, input bit rnd, input string tag);
      op_valid = 1; op_src_a = sa; op_src_b = sb; op_dst = dst; op_sub = sub; op_rnd = rnd;
      cyc(tag);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      idle();
      rd_acc = 0; rd_seg = 0;
      for (int i = 0; i < 4; i++) m_in[i] = '0;
      m_acc[0] = '0; m_acc[1] = '0;
      m_n = 0; m_z = 0; m_v = 0; m_e = 0;
      rst_n = 0;
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1", "acc_a", 64'(acc_a), 64'd0);
      check("R1", "acc_b", 64'(acc_b), 64'd0);
      check("R1", "flags", 64'({flag_n, flag_z, flag_v, flag_e}), 64'd0);
      check("R1", "operands", 64'({x_pair, y_pair} != 0), 64'd0);
      rst_n = 1;

      // R2: operand loads
      load_in(2'd0, 24'h400000);
      load_in(2'd1, 24'h000000);
      load_in(2'd2, 24'h400000);
      load_in(2'd3, 24'hC00000);

      // R5 / R6 basic accumulate and subtract, zero result
      mac(2'd0, 2'd2, 1'b0, 1'b0, 1'b0, "R5");
      mac(2'd0, 2'd3, 1'b1, 1'b1, 1'b0, "R6");
      mac(2'd0, 2'd2, 1'b0, 1'b1, 1'b0, "R6");
      check("R8", "zero flag after cancel", 64'(flag_z), 64'd1);

      // R3 / R4: segment writes and sign-extended extension read
      rd_acc = 0; rd_seg = 2'd0;
      load_seg(1'b0, 2'd0, 24'hABCD80, "R3");
      check("R4", "ext sign extended", 64'(rd_data), 64'h000000FFFF80);
      load_seg(1'b0, 2'd3, 24'h123456, "R3");
      check("R3", "code 3 ignored", 64'(acc_a), 64'h80_000000_000000);
      rd_seg = 2'd3;
      cyc("R4");
      check("R4", "code 3 read", 64'(rd_data), 64'd0);
      rd_seg = 2'd1;

      // R7: tie with even and odd bit 24, above and below half
      set_acc(1'b0, 8'h00, 24'h000002, 24'h800000);
      mac(2'd1, 2'd1, 1'b0, 1'b0, 1'b1, "R7");
      check("R7", "tie even stays", 64'(acc_a), 64'h00_000002_000000);
      set_acc(1'b0, 8'h00, 24'h000003, 24'h800000);
      mac(2'd1, 2'd1, 1'b0, 1'b0, 1'b1, "R7");
      check("R7", "tie odd rounds up", 64'(acc_a), 64'h00_000004_000000);
      set_acc(1'b1, 8'hFF, 24'hFFFFFF, 24'h800001);
      mac(2'd1, 2'd1, 1'b1, 1'b0, 1'b1, "R7");
      check("R7", "above half", 64'(acc_b), 64'h00_000000_000000);
      set_acc(1'b1, 8'h00, 24'h000005, 24'h7FFFFF);
      mac(2'd1, 2'd1, 1'b1, 1'b0, 1'b1, "R7");
      check("R7", "below half", 64'(acc_b), 64'h00_000005_000000);

      // R8: most negative operands squared, extension in use
      load_in(2'd0, 24'h800000);
      load_in(2'd2, 24'h800000);
      set_acc(1'b0, 8'h00, 24'h000000, 24'h000000);
      mac(2'd0, 2'd2, 1'b0, 1'b0, 1'b0, "R8");
      check("R8", "-1 * -1", 64'(acc_a), 64'h00_800000_000000);
      check("R8", "flag_e", 64'(flag_e), 64'd1);

      // R9: subtract and add overflow
      set_acc(1'b0, 8'h80, 24'h000000, 24'h000000);
      mac(2'd0, 2'd0, 1'b0, 1'b1, 1'b0, "R9");
      check("R9", "sub overflow", 64'(flag_v), 64'd1);
      set_acc(1'b1, 8'h7F, 24'hFFFFFF, 24'hFFFFFF);
      mac(2'd0, 2'd2, 1'b1, 1'b0, 1'b0, "R9");
      check("R9", "add overflow", 64'(flag_v), 64'd1);
      mac(2'd1, 2'd1, 1'b1, 1'b0, 1'b0, "R9");
      check("R9", "no overflow clears", 64'(flag_v), 64'd0);

      // R10: operation beats a load to the same accumulator
      op_valid = 1; op_src_a = 2'd0; op_src_b = 2'd2; op_dst = 1'b0;
      acc_we = 1; acc_wsel = 1'b0; acc_wseg = 2'd1; acc_wdata = 24'h555555;
      cyc("R10");
      op_valid = 1; op_src_a = 2'd0; op_src_b = 2'd2; op_dst = 1'b0;
      acc_we = 1; acc_wsel = 1'b1; acc_wseg = 2'd2; acc_wdata = 24'h0000AA;
      cyc("R10");

      // R11: flags hold across idle cycles
      begin
         logic [3:0] held;
         held = {flag_n, flag_z, flag_v, flag_e};
         cyc("R11");
         load_seg(1'b0, 2'd2, 24'h000001, "R11");
         check("R11", "flags held", 64'({flag_n, flag_z, flag_v, flag_e}), 64'(held));
      end

      // R5: random stream
      for (int k = 0; k < 400; k++) begin
         in_we = $urandom_range(0, 3) == 0;
         in_sel = 2'($urandom); in_data = 24'($urandom);
         acc_we = $urandom_range(0, 4) == 0;
         acc_wsel = 1'($urandom); acc_wseg = 2'($urandom); acc_wdata = 24'($urandom);
         op_valid = $urandom_range(0, 2) != 0;
         op_src_a = 2'($urandom); op_src_b = 2'($urandom);
         op_dst = 1'($urandom); op_sub = 1'($urandom); op_rnd = 1'($urandom);
         rd_acc = 1'($urandom); rd_seg = 2'($urandom);
         cyc("R5");
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule